// File: doc/BRIEF.md
# Two-Wire Bus Master Bit Transmitter with Arbitration Monitor

This block sits between a byte engine and the pads of an open-drain, wired-AND two-wire management bus. The byte engine hands it one request at a time: open a transaction, send one bit, close the transaction, or re-open it without closing. The block turns each request into pull-down enables for the data and clock lines. It generates the clock itself and launches each data bit while the clock is held low.

Each step is timed in system clock cycles, using a programmable count for each phase: clock low, clock high, hold after a start condition, setup before a stop or repeated start, and the idle gap between transactions. A timing input of zero selects a built-in default count. After the block releases the clock it waits until the clock line actually reads high, which absorbs clock stretching by slaves. While the clock is high and the block has released the data line, it watches that line. If another master holds the line low, the block has lost arbitration. It then releases both lines, pulses an abort to the byte engine and sets a sticky bus-error flag. That flag can raise an interrupt. Software restarts the transaction.

Top module: `mbus_arb_tx`

## Requirements
- R1: After reset both pull-down enables are off, `cmd_ready` is high, and `abort`, `bus_err` and `irq` are low.
- R2: A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Operation codes are 0 = start, 1 = bit, 2 = stop and 3 = reserved. A start taken while idle pulls the data line low with the clock released for THOLD cycles. It then pulls the clock low and raises `cmd_ready`. `cmd_ready` is low throughout every timed phase.
- R3: A bit request sets the data pull-down to the inverse of `cmd_bit`, so a 1 releases the line and a 0 pulls it low. The clock is pulled low for TLOW cycles and then released. Once the clock line reads high, the clock stays released for THIGH more cycles, and is then pulled low with `cmd_ready` high. The released clock lasts 1 + THIGH cycles when nothing stretches it.
- R4: While the released clock line reads low, the block keeps it released and does not start the high-time count. Each stretched cycle adds one cycle to the bit.
- R5: A stop holds the data line low for TLOW cycles with the clock pulled low. It then releases the clock and, once the clock reads high, keeps the data line low for TSETUP cycles before releasing it. Both lines then stay released with `cmd_ready` low for TBUF cycles, so a start waiting at `cmd_valid` is taken only after that gap.
- R6: A start request made inside a transaction releases the data line and holds the clock low for TLOW cycles. It then releases the clock and, once the clock reads high, waits TSETUP cycles. After that the data line is pulled low, and after THOLD more cycles the clock is pulled low.
- R7: Arbitration is lost when the data line reads low on a high-time or setup cycle in which the block has released it. On the next cycle both lines are released and `abort` is high for exactly one cycle. The transfer is dropped, and a TBUF bus-free wait follows before idle. A data line that the block itself pulls low never counts as a loss.
- R8: `bus_err` rises in the same cycle as `abort`. It stays high until a cycle with `err_clr` high, and is low from the next cycle on.
- R9: `irq` is high exactly when `bus_err` and `irq_en` are both high.
- R10: A timing input of zero selects the parameter default for that phase (defaults: high 5, low 6, start hold 4, setup 4, bus free 7).
- R11: A bit or stop request taken while idle, and a reserved code taken at any time, are consumed with no effect on the lines or on `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 2 | Request code: 0 start, 1 bit, 2 stop, 3 reserved |
| cmd_bit | input | 1 | Bit value for a bit request |
| cmd_ready | output | 1 | Block can take a request this cycle |
| cfg_thigh | input | TW | Clock high cycles (0 = default) |
| cfg_tlow | input | TW | Clock low cycles (0 = default) |
| cfg_thold | input | TW | Start hold cycles (0 = default) |
| cfg_tsetup | input | TW | Stop / repeated start setup cycles (0 = default) |
| cfg_tbuf | input | TW | Bus-free cycles (0 = default) |
| irq_en | input | 1 | Interrupt enable for the bus error |
| err_clr | input | 1 | Clears the bus error flag |
| sda_in | input | 1 | Sampled data line |
| scl_in | input | 1 | Sampled clock line |
| sda_pd | output | 1 | Data line pull-down enable |
| scl_pd | output | 1 | Clock line pull-down enable |
| bus_err | output | 1 | Sticky arbitration-loss flag |
| irq | output | 1 | Interrupt request |
| abort | output | 1 | One-cycle transfer abort to the byte engine |

## Verification
The bench sends bit sequences that mix ones and zeros, with no stretching and with a slave that holds the clock low for several cycles. This separates the launch of the data bit from the measured high time. A second master pulls the data line low while the block sends a 0, while it sends a 1, and during the setup of a repeated start. These cases show that only a released line that reads low counts as a loss, and that the loss is caught in the setup phase as well as in the high phase. A start is held at the request input straight after a stop, which shows that it is taken only once the full bus-free gap has elapsed. Runs with zero timing inputs show that the defaults replace them.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BIT   = 2'd1,
        OP_STOP  = 2'd2,
        OP_RSV   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHOLD,
        ST_LRDY,
        ST_LOW,
        ST_WHI,
        ST_HIGH,
        ST_SETUP,
        ST_BUF
    } st_e;

    typedef enum logic [1:0] {
        K_BIT,
        K_STOP,
        K_RST
    } kind_e;

    localparam int NT      = 5;
    localparam int T_HIGH  = 0;
    localparam int T_LOW   = 1;
    localparam int T_HOLD  = 2;
    localparam int T_SETUP = 3;
    localparam int T_BUF   = 4;

endpackage

// File: rtl/mbus_time_sel.sv
module mbus_time_sel #(
    parameter int              TW  = 8,
    parameter logic [TW-1:0]   DEF = 1
) (
    input  logic [TW-1:0] cfg_i,
    output logic [TW-1:0] eff_o
);
    always_comb begin
        eff_o = (cfg_i == '0) ? DEF : cfg_i;
    end
endmodule

// File: rtl/mbus_arb_det.sv
module mbus_arb_det (
    input  logic check_en,
    input  logic sda_rel,
    input  logic sda_in,
    output logic lost
);
    // a released data line that reads low belongs to another master
    always_comb begin
        lost = check_en && sda_rel && !sda_in;
    end
endmodule

// File: rtl/mbus_err_flag.sv
module mbus_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic err_o,
    output logic irq_o
);
    logic err_d, err_q;

    always_comb begin
        err_d = set_i || (err_q && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_o = err_q;
    assign irq_o = err_q && en_i;
endmodule

// File: rtl/mbus_arb_tx.sv
module mbus_arb_tx #(
    parameter int            TW         = 8,
    parameter logic [TW-1:0] DEF_THIGH  = 5,
    parameter logic [TW-1:0] DEF_TLOW   = 6,
    parameter logic [TW-1:0] DEF_THOLD  = 4,
    parameter logic [TW-1:0] DEF_TSETUP = 4,
    parameter logic [TW-1:0] DEF_TBUF   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_bit,
    output logic          cmd_ready,
    input  logic [TW-1:0] cfg_thigh,
    input  logic [TW-1:0] cfg_tlow,
    input  logic [TW-1:0] cfg_thold,
    input  logic [TW-1:0] cfg_tsetup,
    input  logic [TW-1:0] cfg_tbuf,
    input  logic          irq_en,
    input  logic          err_clr,
    input  logic          sda_in,
    input  logic          scl_in,
    output logic          sda_pd,
    output logic          scl_pd,
    output logic          bus_err,
    output logic          irq,
    output logic          abort
);
    import mbus_pkg::*;

    localparam logic [TW-1:0]      ONE      = 1;
    localparam logic [NT*TW-1:0]   DEF_PACK = {DEF_TBUF, DEF_TSETUP, DEF_THOLD, DEF_TLOW, DEF_THIGH};

    typedef struct packed {
        st_e           st;
        kind_e         kind;
        logic [TW-1:0] cnt;
        logic          sda_pd;
        logic          scl_pd;
        logic          abort;
    } regs_t;

    regs_t r_d, r_q;

    logic [NT*TW-1:0] cfg_pack;
    logic [TW-1:0]    t_eff [NT];
    logic             lost;
    logic             accept;
    op_e              op;

    assign cfg_pack = {cfg_tbuf, cfg_tsetup, cfg_thold, cfg_tlow, cfg_thigh};

    for (genvar g = 0; g < NT; g++) begin : g_tsel
        mbus_time_sel #(
            .TW  (TW),
            .DEF (DEF_PACK[g*TW +: TW])
        ) u_tsel (
            .cfg_i (cfg_pack[g*TW +: TW]),
            .eff_o (t_eff[g])
        );
    end

    mbus_arb_det u_arb (
        .check_en (r_q.st == ST_HIGH || r_q.st == ST_SETUP),
        .sda_rel  (!r_q.sda_pd),
        .sda_in   (sda_in),
        .lost     (lost)
    );

    mbus_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (lost),
        .clr_i (err_clr),
        .en_i  (irq_en),
        .err_o (bus_err),
        .irq_o (irq)
    );

    assign cmd_ready = (r_q.st == ST_IDLE) || (r_q.st == ST_LRDY);
    assign accept    = cmd_valid && cmd_ready;
    assign op        = op_e'(cmd_op);

    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept && op == OP_START) begin
                    r_d.st     = ST_SHOLD;
                    r_d.sda_pd = 1'b1;
                    r_d.cnt    = t_eff[T_HOLD] - ONE;
                end
            end
            ST_SHOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_LRDY;
                    r_d.scl_pd = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_LRDY: begin
                if (accept) begin
                    case (op)
                        OP_BIT: begin
                            r_d.st     = ST_LOW;
                            r_d.kind   = K_BIT;
                            r_d.sda_pd = !cmd_bit;
                            r_d.cnt    = t_eff[T_LOW] - ONE;
                        end
                        OP_STOP: begin
                            r_d.st     = ST_LOW;
                            r_d.kind   = K_STOP;
                            r_d.sda_pd = 1'b1;
                            r_d.cnt    = t_eff[T_LOW] - ONE;
                        end
                        OP_START: begin
                            r_d.st     = ST_LOW;
                            r_d.kind   = K_RST;
                            r_d.sda_pd = 1'b0;
                            r_d.cnt    = t_eff[T_LOW] - ONE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_WHI;
                    r_d.scl_pd = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_WHI: begin
                if (scl_in) begin
                    if (r_q.kind == K_BIT) begin
                        r_d.st  = ST_HIGH;
                        r_d.cnt = t_eff[T_HIGH] - ONE;
                    end else begin
                        r_d.st  = ST_SETUP;
                        r_d.cnt = t_eff[T_SETUP] - ONE;
                    end
                end
            end
            ST_HIGH, ST_SETUP: begin
                if (lost) begin
                    r_d.st     = ST_BUF;
                    r_d.sda_pd = 1'b0;
                    r_d.scl_pd = 1'b0;
                    r_d.abort  = 1'b1;
                    r_d.cnt    = t_eff[T_BUF] - ONE;
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - ONE;
                end else if (r_q.st == ST_HIGH) begin
                    r_d.st     = ST_LRDY;
                    r_d.scl_pd = 1'b1;
                end else if (r_q.kind == K_STOP) begin
                    r_d.st     = ST_BUF;
                    r_d.sda_pd = 1'b0;
                    r_d.cnt    = t_eff[T_BUF] - ONE;
                end else begin
                    r_d.st     = ST_SHOLD;
                    r_d.sda_pd = 1'b1;
                    r_d.cnt    = t_eff[T_HOLD] - ONE;
                end
            end
            ST_BUF: begin
                if (r_q.cnt == '0) r_d.st  = ST_IDLE;
                else               r_d.cnt = r_q.cnt - ONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.kind   <= K_BIT;
            r_q.cnt    <= '0;
            r_q.sda_pd <= 1'b0;
            r_q.scl_pd <= 1'b0;
            r_q.abort  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pd = r_q.sda_pd;
    assign scl_pd = r_q.scl_pd;
    assign abort  = r_q.abort;

endmodule

// File: rtl/mbus_arb_tx_chk.sv
module mbus_arb_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic bus_err,
    input logic irq,
    input logic irq_en,
    input logic err_clr,
    input logic sda_pd,
    input logic scl_pd
);
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);                                   // R7
    AST_ABORT_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!sda_pd && !scl_pd));                     // R7
    AST_ABORT_WAS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(!sda_pd));                           // R7
    AST_ERR_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> bus_err);                           // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_clr) |=> bus_err);                  // R8
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && bus_err));                        // R9
endmodule

bind mbus_arb_tx mbus_arb_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .bus_err (bus_err),
    .irq     (irq),
    .irq_en  (irq_en),
    .err_clr (err_clr),
    .sda_pd  (sda_pd),
    .scl_pd  (scl_pd)
);

// File: tb/mbus_arb_tx_bench.sv
`timescale 1ns/1ps
module mbus_arb_tx_bench;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_bit = 1'b0;
    logic          cmd_ready;
    logic [TW-1:0] cfg_thigh = 8'd3, cfg_tlow = 8'd4, cfg_thold = 8'd2;
    logic [TW-1:0] cfg_tsetup = 8'd3, cfg_tbuf = 8'd5;
    logic          irq_en = 1'b1;
    logic          err_clr = 1'b0;
    logic          sda_in, scl_in;
    logic          sda_pd, scl_pd, bus_err, irq, abort;

    logic          other_pd = 1'b0;
    int            stretch_amt = 0;
    int            rel_cnt = 0;

    always #5 clk = ~clk;

    // wired-AND bus: slave holds clock low for stretch_amt cycles after each release
    assign sda_in = !sda_pd && !other_pd;
    assign scl_in = !scl_pd && (rel_cnt >= stretch_amt);

    always @(posedge clk) begin
        if (scl_pd) rel_cnt <= 0;
        else        rel_cnt <= rel_cnt + 1;
    end

    mbus_arb_tx #(.TW(TW)) u_mbus_arb_tx (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_ready(cmd_ready), .cfg_thigh(cfg_thigh),
        .cfg_tlow(cfg_tlow), .cfg_thold(cfg_thold), .cfg_tsetup(cfg_tsetup),
        .cfg_tbuf(cfg_tbuf), .irq_en(irq_en), .err_clr(err_clr),
        .sda_in(sda_in), .scl_in(scl_in), .sda_pd(sda_pd), .scl_pd(scl_pd),
        .bus_err(bus_err), .irq(irq), .abort(abort)
    );

    // reference model: expected {abort, ready, sda_pd, scl_pd} per cycle
    logic [3:0] q[$];
    logic [1:0] rest = 2'b00;
    logic       exp_err = 1'b0;
    logic       at_rest = 1'b0;
    string      tag = "R1";
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    function automatic int eff(input logic [TW-1:0] v, input int def);
        return (v == 0) ? def : int'(v);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] e;
            logic [5:0] act, exp_v;
            if (q.size() > 0) begin
                e = q.pop_front();
                at_rest = 1'b0;
            end else begin
                e = {1'b0, 1'b1, rest};
                at_rest = 1'b1;
            end
            if (e[3]) exp_err = 1'b1;
            exp_v = {e, exp_err, exp_err && irq_en};
            act   = {abort, cmd_ready, sda_pd, scl_pd, bus_err, irq};
            checks++;
            if (act !== exp_v) begin
                failures++;
                $display("FAIL %s t=%0t {abort,ready,sda_pd,scl_pd,err,irq} actual=%b expected=%b",
                         tag, $time, act, exp_v);
            end
        end
    end

    task automatic push(input int n, input logic s, input logic c);
        for (int i = 0; i < n; i++) q.push_back({2'b00, s, c});
    endtask

    task automatic push_loss(input logic s);
        push(eff(cfg_tlow, 6), s, 1'b1);
        push(2, s, 1'b0);
        q.push_back(4'b1000);
        push(eff(cfg_tbuf, 7) - 1, 1'b0, 1'b0);
        rest = 2'b00;
    endtask

    task automatic issue(input logic [1:0] op, input logic b);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bit   = b;
        do begin
            @(negedge clk);
            #1;
        end while (!at_rest);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic do_start();
        issue(2'd0, 1'b0);
        push(eff(cfg_thold, 4), 1'b1, 1'b0);
        rest = 2'b11;
    endtask

    task automatic do_bit(input logic b, input int s, input bit lose);
        issue(2'd1, b);
        stretch_amt = s;
        if (lose) begin
            push_loss(!b);
        end else begin
            push(eff(cfg_tlow, 6), !b, 1'b1);
            push(1 + s + eff(cfg_thigh, 5), !b, 1'b0);
            rest = {!b, 1'b1};
        end
    endtask

    task automatic do_rstart(input int s, input bit lose);
        issue(2'd0, 1'b0);
        stretch_amt = s;
        if (lose) begin
            push_loss(1'b0);
        end else begin
            push(eff(cfg_tlow, 6), 1'b0, 1'b1);
            push(1 + s + eff(cfg_tsetup, 4), 1'b0, 1'b0);
            push(eff(cfg_thold, 4), 1'b1, 1'b0);
            rest = 2'b11;
        end
    endtask

    task automatic do_stop(input int s);
        issue(2'd2, 1'b0);
        stretch_amt = s;
        push(eff(cfg_tlow, 6), 1'b1, 1'b1);
        push(1 + s + eff(cfg_tsetup, 4), 1'b1, 1'b0);
        push(eff(cfg_tbuf, 7), 1'b0, 1'b0);
        rest = 2'b00;
    endtask

    task automatic settle();
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
        stretch_amt = 0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(posedge clk);
        #1;
        err_clr = 1'b0;
        exp_err = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R1";
        repeat (3) @(posedge clk);
        #1;

        tag = "R11"; issue(2'd1, 1'b1); issue(2'd2, 1'b0); issue(2'd3, 1'b0); settle();
        tag = "R2";  do_start(); settle();
        tag = "R3";  do_bit(1'b1, 0, 0); do_bit(1'b0, 0, 0); do_bit(1'b1, 0, 0); settle();
        tag = "R4";  do_bit(1'b0, 3, 0); settle(); do_bit(1'b1, 5, 0); settle();
        tag = "R11"; issue(2'd3, 1'b1); settle();
        tag = "R6";  do_rstart(2, 0); settle();
        tag = "R3";  do_bit(1'b0, 0, 0); settle();
        tag = "R5";  do_stop(1); do_start(); settle();
        tag = "R7";  other_pd = 1'b1; do_bit(1'b0, 0, 0); settle();
        tag = "R7";  do_bit(1'b1, 0, 1); settle(); other_pd = 1'b0;
        tag = "R9";  repeat (3) @(posedge clk); #1;
        tag = "R8";  repeat (4) @(posedge clk); #1; clear_err(); settle();
        tag = "R7";  do_start(); other_pd = 1'b1; do_rstart(0, 1); settle(); other_pd = 1'b0;
        tag = "R9";  irq_en = 1'b0; repeat (3) @(posedge clk); #1;
        irq_en = 1'b1; repeat (2) @(posedge clk); #1;
        tag = "R8";  clear_err(); settle();
        tag = "R10"; cfg_tlow = 8'd0; cfg_tbuf = 8'd0; cfg_thigh = 8'd0;
        repeat (2) @(posedge clk); #1;
        do_start(); do_bit(1'b1, 0, 0); do_bit(1'b0, 1, 0); do_stop(0); do_start(); settle();
        cfg_thold = 8'd0; cfg_tsetup = 8'd0;
        repeat (2) @(posedge clk); #1;
        do_rstart(0, 0); do_stop(0); settle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule